// File: doc/BRIEF.md
# Sample Memory Access Bridge

This block sits between an 8-bit host bus and a wavetable sound chip that has its own sample memory bus. It decodes a 256-byte register window. Offsets below 0xF0 belong to the sound chip and get its chip select. Offsets 0xF0 and above belong to the bridge. There the host loads a 24-bit sample memory address as three separately latched bytes. It then reads or writes external sample SRAM through a single data port.

Only the host may touch the SRAM, and only while the bus-phase clock `e_phase` is high; while it is low the sound chip drives the sample memory bus. The sound chip never writes sample memory, so the bridge generates every write address and write strobe. An optional auto-increment moves the address forward after each data port access, which lets the host stream a whole sample buffer.

Register map: 0xF0 address low byte, 0xF1 address middle byte, 0xF2 address high byte, 0xF3 data port, 0xF4 control (bit 0 = auto-increment enable). Offsets 0xF5 to 0xFF are unused.

Top module: `sram_bridge`

## Requirements
- R1: `snd_sel` is high in the same cycle exactly when `host_sel` is high and `host_addr` is 0x00 to 0xEF. It is never high for 0xF0 to 0xFF.
- R2: A write strobe to 0xF0, 0xF1 or 0xF2 pulses `lat_en` bit 0, 1 or 2 respectively in that cycle. At most one bit is ever set. From the next cycle the low, middle or high byte of `sram_addr` holds the written data.
- R3: A write to 0xF3 while `e_phase` is high raises `sram_we` in that cycle, with `sram_addr` equal to the latched address and `sram_wdata` equal to `host_wdata`.
- R4: A read of 0xF3 while `e_phase` is high raises `sram_oe` in that cycle. The next cycle, `host_rdata` holds the `sram_rdata` value present at that clock edge.
- R5: With control bit 0 set, each data port access made while `e_phase` is high advances the 24-bit address by one after the access, wrapping from 0xFFFFFF to 0x000000. With the bit clear, the address is unchanged.
- R6: A data port access while `e_phase` is low raises neither `sram_oe` nor `sram_we`. It leaves the address unchanged, and such a read returns 0x00.
- R7: A read of 0xF0, 0xF1, 0xF2 or 0xF4 returns the current register value on `host_rdata` one cycle after the read strobe. Bits 7:1 of 0xF4 read as 0.
- R8: Writes to 0xF5 to 0xFF change no state and read back as 0x00. Bridge reads of offsets below 0xF0, and cycles without a read strobe, give `host_rdata` = 0x00.
- R9: A synchronous reset clears the address, the control bit and `host_rdata` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_sel | input | 1 | Host selects the register window |
| host_addr | input | 8 | Offset within the window |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Bridge read data, one cycle after the read strobe |
| e_phase | input | 1 | Bus-phase clock, high while the host owns the bus |
| snd_sel | output | 1 | Sound chip chip select, active high |
| lat_en | output | 3 | Address byte latch enables (low, mid, high) |
| sram_addr | output | 24 | Sample SRAM address |
| sram_wdata | output | 8 | Sample SRAM write data |
| sram_rdata | input | 8 | Sample SRAM read data |
| sram_oe | output | 1 | Sample SRAM output enable, active high |
| sram_we | output | 1 | Sample SRAM write strobe, active high |

## Verification
The chip select, latch enables and SRAM strobes are combinational, so they are due in the same cycle as the host strobe. The bench checks them shortly after driving the inputs on the falling edge. Register loads, the address step and `host_rdata` take effect one rising edge later. The bench samples them at the following falling edge and compares them against its model state before that model absorbs the next access. Random accesses mix E phases, offsets and auto-increment settings, and directed cases cover the address wrap and reset.

// File: rtl/sram_bridge.sv
module sram_bridge #(
  parameter logic [7:0] BASE       = 8'hF0,
  parameter int         ADDR_BYTES = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    host_sel,
  input  logic [7:0]              host_addr,
  input  logic                    host_wr,
  input  logic                    host_rd,
  input  logic [7:0]              host_wdata,
  output logic [7:0]              host_rdata,
  input  logic                    e_phase,
  output logic                    snd_sel,
  output logic [ADDR_BYTES-1:0]   lat_en,
  output logic [8*ADDR_BYTES-1:0] sram_addr,
  output logic [7:0]              sram_wdata,
  input  logic [7:0]              sram_rdata,
  output logic                    sram_oe,
  output logic                    sram_we
);
  localparam int         AW        = 8 * ADDR_BYTES;
  localparam logic [7:0] OFS_DATA  = 8'(BASE + ADDR_BYTES);
  localparam logic [7:0] OFS_CTRL  = 8'(BASE + ADDR_BYTES + 1);

  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_inc;
  logic          inc_q;
  logic [7:0]    rd_mux;
  logic          wr_hit, rd_hit, dp_hit, step;

  assign wr_hit   = host_sel && host_wr;
  assign rd_hit   = host_sel && host_rd && !host_wr;
  assign snd_sel  = host_sel && (host_addr < BASE);
  assign dp_hit   = host_sel && e_phase && (host_addr == OFS_DATA);
  assign sram_we  = dp_hit && host_wr;
  assign sram_oe  = dp_hit && host_rd && !host_wr;
  assign step     = (sram_we || sram_oe) && inc_q;
  assign addr_inc = addr_q + AW'(1);

  assign sram_addr  = addr_q;
  assign sram_wdata = host_wdata;

  for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_byte
    assign lat_en[i] = wr_hit && (host_addr == 8'(BASE + i));
    always_ff @(posedge clk) begin
      if (rst)            addr_q[8*i +: 8] <= '0;
      else if (lat_en[i]) addr_q[8*i +: 8] <= host_wdata;
      else if (step)      addr_q[8*i +: 8] <= addr_inc[8*i +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                 inc_q <= 1'b0;
    else if (wr_hit && host_addr == OFS_CTRL) inc_q <= host_wdata[0];
  end

  always_comb begin
    rd_mux = 8'h00;
    for (int i = 0; i < ADDR_BYTES; i++)
      if (host_addr == 8'(BASE + i)) rd_mux = addr_q[8*i +: 8];
    if (host_addr == OFS_DATA) rd_mux = sram_oe ? sram_rdata : 8'h00;
    if (host_addr == OFS_CTRL) rd_mux = {7'd0, inc_q};
  end

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= 8'h00;
    else     host_rdata <= rd_hit ? rd_mux : 8'h00;
  end

  AST_SEL_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(snd_sel && (sram_oe || sram_we || (|lat_en)))); // R1
  AST_LAT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lat_en)); // R2
  AST_NO_STROBE_E_LOW: assert property (@(posedge clk) disable iff (rst)
    !e_phase |-> !sram_oe && !sram_we); // R6
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (sram_oe || sram_we) && inc_q |=> sram_addr == $past(sram_addr) + AW'(1)); // R5
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !sram_oe && !sram_we && lat_en == '0 |=> $stable(sram_addr)); // R2
  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> host_rdata == 8'h00); // R8
endmodule

// File: tb/sim_sram_bridge.sv
module sim_sram_bridge;
  logic clk = 0, rst = 1;
  logic host_sel = 0, host_wr = 0, host_rd = 0, e_phase = 0;
  logic [7:0] host_addr = 0, host_wdata = 0, host_rdata, sram_wdata, sram_rdata;
  logic snd_sel, sram_oe, sram_we;
  logic [2:0] lat_en;
  logic [23:0] sram_addr;
  int vectors = 0, misses = 0;

  logic [23:0] m_addr;
  logic m_inc;
  logic [7:0] m_rdata;

  always #5 clk = ~clk;

  function automatic logic [7:0] pat(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[23:20]} ^ 8'h5A;
  endfunction
  assign sram_rdata = sram_oe ? pat(sram_addr) : 8'hEE;

  sram_bridge u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [7:0] a, input logic e);
    case (a)
      8'hF0: return m_addr[7:0];
      8'hF1: return m_addr[15:8];
      8'hF2: return m_addr[23:16];
      8'hF3: return e ? pat(m_addr) : 8'h00;
      8'hF4: return {7'd0, m_inc};
      default: return 8'h00;
    endcase
  endfunction

  task automatic op(input logic s, input logic [7:0] a, input logic w, input logic r,
                    input logic [7:0] d, input logic e);
    logic dp;
    @(negedge clk);
    chk("R7/R4/R8 rdata", host_rdata, m_rdata);
    chk("R2/R5 addr", sram_addr, m_addr);
    host_sel = s; host_addr = a; host_wr = w; host_rd = r; host_wdata = d; e_phase = e;
    #1;
    dp = s && e && a == 8'hF3;
    chk("R1 snd_sel", snd_sel, s && a < 8'hF0);
    chk("R2 lat_en", lat_en, {s && w && a == 8'hF2, s && w && a == 8'hF1, s && w && a == 8'hF0});
    chk("R3/R6 we", sram_we, dp && w);
    chk("R4/R6 oe", sram_oe, dp && r && !w);
    if (dp && w) chk("R3 wdata", sram_wdata, d);
    m_rdata = (s && r && !w) ? exp_read(a, e) : 8'h00;
    if (s && w) begin
      case (a)
        8'hF0: m_addr[7:0] = d;
        8'hF1: m_addr[15:8] = d;
        8'hF2: m_addr[23:16] = d;
        8'hF4: m_inc = d[0];
        default: ;
      endcase
    end
    if (dp && (w || r) && m_inc) m_addr = m_addr + 24'd1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; host_sel = 0; host_wr = 0; host_rd = 0;
    @(negedge clk);
    chk("R9 rdata", host_rdata, 8'h00);
    chk("R9 addr", sram_addr, 24'h0);
    rst = 0;
    m_addr = 0; m_inc = 0; m_rdata = 0;
    op(1, 8'hF4, 0, 1, 0, 1);
  endtask

  initial begin
    #2_000_000;
    misses++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_addr = 0; m_inc = 0; m_rdata = 0;
    repeat (2) @(negedge clk);
    do_reset();
    // R5 wrap
    op(1, 8'hF0, 1, 0, 8'hFF, 1);
    op(1, 8'hF1, 1, 0, 8'hFF, 1);
    op(1, 8'hF2, 1, 0, 8'hFF, 1);
    op(1, 8'hF4, 1, 0, 8'h01, 1);
    op(1, 8'hF3, 1, 0, 8'h3C, 1);
    op(1, 8'hF0, 0, 1, 0, 1);
    op(1, 8'hF2, 0, 1, 0, 1);
    // R6 E low
    op(1, 8'hF3, 0, 1, 0, 0);
    op(1, 8'hF3, 1, 0, 8'h11, 0);
    // R8 unused
    op(1, 8'hF7, 1, 0, 8'hAB, 1);
    op(1, 8'hF7, 0, 1, 0, 1);
    op(1, 8'h40, 0, 1, 0, 1);
    // R4 reads at a fresh address with increment on
    op(1, 8'hF0, 1, 0, 8'h10, 1);
    op(1, 8'hF3, 0, 1, 0, 1);
    op(1, 8'hF3, 0, 1, 0, 1);
    op(1, 8'hF4, 0, 1, 0, 1);
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] a;
      logic w;
      a = ($urandom % 4 == 0) ? 8'($urandom) : 8'hF0 | 8'($urandom % 16);
      w = 1'($urandom);
      op(($urandom % 8) != 0, a, w, !w && ($urandom % 4 != 0), 8'($urandom), 1'($urandom));
      if (n == 2000) do_reset();
    end
    op(0, 8'h00, 0, 0, 0, 0);
    @(negedge clk);
    chk("R8 final rdata", host_rdata, m_rdata);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule